// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register Block

This block holds the routing table of a 24-input interrupt router behind a two-register memory-mapped window. Software first writes an index into a select register, then reads or writes a 32-bit data window. That window reaches an identification word, a version word, an arbitration word and one 64-bit redirection entry for each input pin. Each entry is split into an even index for its low word and an odd index for its high word.

The stored entries are decoded and driven out as per-pin field vectors: vector, delivery mode, destination mode, polarity, remote-pending, trigger mode, mask and destination. The pin-servicing logic reads these vectors. It drives the remote-pending flags through set and clear strobes, and it receives a one-cycle update pulse carrying the entry number whenever an entry is rewritten. It uses that pulse to re-service an input that is still pending. Writing an entry's low word always drops its remote-pending flag.

Top module: `irq_route_regs`

## Requirements
- R1: After reset every entry reads 0x00010000 in its low word (mask bit 16 set, all else 0) and 0 in its high word, the ID is 0, the select register reads 0 and no update pulse is driven.
- R2: Only the low 8 bits of the bus address are decoded. Offset 0x00 is the read/write select register and offset 0x10 is the data window. Reads of any other offset return 0 and writes to them change nothing.
- R3: A write is taken only when its byte size is 4 or 8. Any other size, at any offset, changes no state and produces no update pulse.
- R4: Window index 0x00 and index 0x02 both read the 4-bit ID in bits 27:24 with all other bits 0. A write to index 0x00 loads the ID from data bits 27:24, and a write to index 0x02 is ignored.
- R5: Window index 0x01 reads (pins-1) in bits 23:16 and 0x11 in bits 7:0, which is 0x00170011 for 24 pins. Writes to it are ignored.
- R6: Entry n is read and written as its low word at index 0x10+2n and as its high word at index 0x11+2n, with all 32 bits stored as written.
- R7: A low-word write forces remote-pending (bit 14) to 0 regardless of the data. A high-word write leaves remote-pending unchanged.
- R8: Per-pin outputs follow the entry layout: bits 7:0 vector, 10:8 delivery mode, 11 destination mode, 13 polarity, 14 remote-pending, 15 trigger mode (1 = level), 16 mask, 63:56 destination.
- R9: Indices 0x03 to 0x0F and any index at or beyond 0x10+2*pins read 0, and writes to them change no stored word.
- R10: Each accepted write to an entry word raises upd_valid with upd_index = n for exactly the cycle after the write edge, in the same cycle the new contents appear. No other write raises it.
- R11: A remote_set strobe sets the pin's remote-pending flag on the next edge and remote_clr clears it. Clear wins over set, and a same-cycle low-word write wins over both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_addr | input | ADDR_W | Byte address; low 8 bits decoded |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when no read |
| remote_set | input | NPINS | Per-pin remote-pending set strobe |
| remote_clr | input | NPINS | Per-pin remote-pending clear strobe |
| pin_vector | output | NPINS*8 | Vector of each entry |
| pin_dlv_mode | output | NPINS*3 | Delivery mode of each entry |
| pin_dst_mode | output | NPINS | Destination mode of each entry |
| pin_polarity | output | NPINS | Polarity of each entry |
| pin_remote | output | NPINS | Remote-pending flag of each entry |
| pin_level | output | NPINS | Trigger mode (1 = level) of each entry |
| pin_mask | output | NPINS | Mask of each entry |
| pin_dest | output | NPINS*8 | Destination of each entry |
| upd_valid | output | 1 | Entry-rewritten pulse |
| upd_index | output | IDX_W | Entry number for upd_valid |

## Verification
The assertions assume that bus_wr and bus_rd strobes last a single cycle, that the address and size are stable while a strobe is high, and that the remote strobes alone move remote-pending when no bus write is in flight. The bench drives every access for exactly one cycle from the falling edge and leaves the remote strobes low except in the cycles that test them. It samples read data and pin outputs one falling edge later, so each check falls in the cycle after the edge that updated the state.

// File: rtl/irr_pkg.sv
`timescale 1ns/1ps
package irr_pkg;

    localparam logic [7:0] SEL_OFS  = 8'h00;
    localparam logic [7:0] WIN_OFS  = 8'h10;
    localparam int unsigned ENT_BASE = 16;
    localparam logic [7:0] VER_CODE = 8'h11;

    typedef struct packed {
        logic [7:0]  dest;
        logic [38:0] rsv;
        logic        mask;
        logic        level;
        logic        remote;
        logic        polarity;
        logic        dstat;
        logic        dst_mode;
        logic [2:0]  dlv_mode;
        logic [7:0]  vector;
    } entry_t;

    localparam entry_t ENTRY_RST = '{mask: 1'b1, default: '0};

endpackage

// File: rtl/irr_bus_decode.sv
`timescale 1ns/1ps
module irr_bus_decode
    import irr_pkg::*;
#(
    parameter int NPINS  = 24,
    parameter int ADDR_W = 12,
    localparam int IDX_W = $clog2(NPINS)
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_size,
    input  logic [31:0]       sel_q,
    output logic              sel_we,
    output logic              id_we,
    output logic              ent_hit,
    output logic              ent_hi,
    output logic [IDX_W-1:0]  ent_idx,
    output logic [NPINS-1:0]  lo_we,
    output logic [NPINS-1:0]  hi_we
);
    localparam logic [31:0] ENT_END = 32'(ENT_BASE + 2 * NPINS);

    logic size_ok;
    logic win_we;

    always_comb begin
        size_ok = (bus_size == 4'd4) || (bus_size == 4'd8);
        sel_we  = bus_wr && size_ok && (bus_addr[7:0] == SEL_OFS);
        win_we  = bus_wr && size_ok && (bus_addr[7:0] == WIN_OFS);
        id_we   = win_we && (sel_q == 32'd0);
        ent_hit = (sel_q >= 32'(ENT_BASE)) && (sel_q < ENT_END);
        ent_hi  = sel_q[0];
        ent_idx = IDX_W'((sel_q - 32'(ENT_BASE)) >> 1);
    end

    for (genvar g = 0; g < NPINS; g++) begin : g_we
        always_comb begin
            lo_we[g] = win_we && ent_hit && !ent_hi && (ent_idx == IDX_W'(g));
            hi_we[g] = win_we && ent_hit &&  ent_hi && (ent_idx == IDX_W'(g));
        end
    end

endmodule

// File: rtl/irr_entry_bank.sv
`timescale 1ns/1ps
module irr_entry_bank
    import irr_pkg::*;
#(
    parameter int NPINS = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] lo_we,
    input  logic [NPINS-1:0] hi_we,
    input  logic [31:0]      wdata,
    input  logic [NPINS-1:0] remote_set,
    input  logic [NPINS-1:0] remote_clr,
    output entry_t           ents [NPINS]
);

    for (genvar g = 0; g < NPINS; g++) begin : g_ent
        entry_t e_d, e_q;

        always_comb begin
            e_d = e_q;
            if (hi_we[g]) e_d[63:32] = wdata;
            if (lo_we[g]) e_d[31:0]  = wdata;
            // strobes act on the held flag; clear dominates set
            e_d.remote = (e_q.remote | remote_set[g]) & ~remote_clr[g];
            // a low-word rewrite re-arms the entry unconditionally
            if (lo_we[g]) e_d.remote = 1'b0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) e_q <= ENTRY_RST;
            else        e_q <= e_d;
        end

        assign ents[g] = e_q;
    end

endmodule

// File: rtl/irr_read_mux.sv
`timescale 1ns/1ps
module irr_read_mux
    import irr_pkg::*;
#(
    parameter int NPINS  = 24,
    parameter int ADDR_W = 12,
    localparam int IDX_W = $clog2(NPINS)
) (
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       sel_q,
    input  logic [3:0]        id_q,
    input  logic              ent_hit,
    input  logic              ent_hi,
    input  logic [IDX_W-1:0]  ent_idx,
    input  entry_t            ents [NPINS],
    output logic [31:0]       rdata
);
    localparam logic [31:0] VER_WORD = {8'h00, 8'(NPINS - 1), 8'h00, VER_CODE};

    logic [31:0] win_val;
    entry_t      pick;

    always_comb begin
        pick    = ents[ent_idx];
        win_val = '0;
        if (sel_q == 32'd1)
            win_val = VER_WORD;
        else if (sel_q == 32'd0 || sel_q == 32'd2)
            win_val = {4'h0, id_q, 24'h0};
        else if (ent_hit)
            win_val = ent_hi ? pick[63:32] : pick[31:0];

        rdata = '0;
        if (bus_rd) begin
            if (bus_addr[7:0] == SEL_OFS)      rdata = sel_q;
            else if (bus_addr[7:0] == WIN_OFS) rdata = win_val;
        end
    end

endmodule

// File: rtl/irq_route_regs.sv
`timescale 1ns/1ps
module irq_route_regs
    import irr_pkg::*;
#(
    parameter int NPINS  = 24,
    parameter int ADDR_W = 12,
    localparam int IDX_W = $clog2(NPINS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [3:0]         bus_size,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NPINS-1:0]   remote_set,
    input  logic [NPINS-1:0]   remote_clr,
    output logic [NPINS*8-1:0] pin_vector,
    output logic [NPINS*3-1:0] pin_dlv_mode,
    output logic [NPINS-1:0]   pin_dst_mode,
    output logic [NPINS-1:0]   pin_polarity,
    output logic [NPINS-1:0]   pin_remote,
    output logic [NPINS-1:0]   pin_level,
    output logic [NPINS-1:0]   pin_mask,
    output logic [NPINS*8-1:0] pin_dest,
    output logic               upd_valid,
    output logic [IDX_W-1:0]   upd_index
);

    typedef struct packed {
        logic [31:0]      sel;
        logic [3:0]       id;
        logic             upd_v;
        logic [IDX_W-1:0] upd_i;
    } state_t;

    state_t st_d, st_q;

    logic             sel_we, id_we, ent_hit, ent_hi;
    logic [IDX_W-1:0] ent_idx;
    logic [NPINS-1:0] lo_we, hi_we;
    entry_t           ents [NPINS];

    irr_bus_decode #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_dec (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_size (bus_size),
        .sel_q    (st_q.sel),
        .sel_we   (sel_we),
        .id_we    (id_we),
        .ent_hit  (ent_hit),
        .ent_hi   (ent_hi),
        .ent_idx  (ent_idx),
        .lo_we    (lo_we),
        .hi_we    (hi_we)
    );

    irr_entry_bank #(.NPINS(NPINS)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .lo_we      (lo_we),
        .hi_we      (hi_we),
        .wdata      (bus_wdata),
        .remote_set (remote_set),
        .remote_clr (remote_clr),
        .ents       (ents)
    );

    irr_read_mux #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_rmux (
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .sel_q    (st_q.sel),
        .id_q     (st_q.id),
        .ent_hit  (ent_hit),
        .ent_hi   (ent_hi),
        .ent_idx  (ent_idx),
        .ents     (ents),
        .rdata    (bus_rdata)
    );

    always_comb begin
        st_d       = st_q;
        st_d.upd_v = |(lo_we | hi_we);
        st_d.upd_i = st_d.upd_v ? ent_idx : '0;
        if (sel_we) st_d.sel = bus_wdata;
        if (id_we)  st_d.id  = bus_wdata[27:24];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign upd_valid = st_q.upd_v;
    assign upd_index = st_q.upd_i;

    for (genvar g = 0; g < NPINS; g++) begin : g_pins
        assign pin_vector[g*8 +: 8]   = ents[g].vector;
        assign pin_dlv_mode[g*3 +: 3] = ents[g].dlv_mode;
        assign pin_dst_mode[g]        = ents[g].dst_mode;
        assign pin_polarity[g]        = ents[g].polarity;
        assign pin_remote[g]          = ents[g].remote;
        assign pin_level[g]           = ents[g].level;
        assign pin_mask[g]            = ents[g].mask;
        assign pin_dest[g*8 +: 8]     = ents[g].dest;
    end

endmodule

// File: rtl/irq_route_regs_chk.sv
`timescale 1ns/1ps
module irq_route_regs_chk #(
    parameter int NPINS  = 24,
    parameter int ADDR_W = 12,
    localparam int IDX_W = $clog2(NPINS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [3:0]         bus_size,
    input logic [31:0]        bus_rdata,
    input logic [NPINS-1:0]   remote_set,
    input logic [NPINS-1:0]   remote_clr,
    input logic [NPINS*8-1:0] pin_vector,
    input logic [NPINS-1:0]   pin_mask,
    input logic [NPINS-1:0]   pin_remote,
    input logic               upd_valid,
    input logic [IDX_W-1:0]   upd_index
);

    assert_upd_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (int'(upd_index) < NPINS));

    assert_upd_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> $past(bus_wr));

    assert_badsize_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_size != 4'd4 && bus_size != 4'd8)
        |=> (!upd_valid && $stable(pin_vector) && $stable(pin_mask)));

    assert_hole_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[7:0] != 8'h00 && bus_addr[7:0] != 8'h10)
        |-> (bus_rdata == 32'd0));

    assert_remote_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ((pin_remote & $past(remote_set & ~remote_clr))
                     == $past(remote_set & ~remote_clr)));

    assert_remote_clr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ((pin_remote & $past(remote_clr)) == '0));

endmodule

bind irq_route_regs irq_route_regs_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_size   (bus_size),
    .bus_rdata  (bus_rdata),
    .remote_set (remote_set),
    .remote_clr (remote_clr),
    .pin_vector (pin_vector),
    .pin_mask   (pin_mask),
    .pin_remote (pin_remote),
    .upd_valid  (upd_valid),
    .upd_index  (upd_index)
);

// File: tb/irq_route_regs_bench.sv
`timescale 1ns/1ps
module irq_route_regs_bench;
    localparam int NPINS  = 24;
    localparam int ADDR_W = 12;
    localparam int IDX_W  = $clog2(NPINS);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               bus_wr = 1'b0, bus_rd = 1'b0;
    logic [ADDR_W-1:0]  bus_addr = '0;
    logic [3:0]         bus_size = 4'd4;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;
    logic [NPINS-1:0]   remote_set = '0, remote_clr = '0;
    logic [NPINS*8-1:0] pin_vector, pin_dest;
    logic [NPINS*3-1:0] pin_dlv_mode;
    logic [NPINS-1:0]   pin_dst_mode, pin_polarity, pin_remote, pin_level, pin_mask;
    logic               upd_valid;
    logic [IDX_W-1:0]   upd_index;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    irq_route_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_irq_route_regs (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [3:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_size = 4'd4;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic win_write(input logic [31:0] idx, input logic [31:0] d);
        bus_write(12'h000, 4'd4, idx);
        bus_write(12'h010, 4'd4, d);
    endtask

    task automatic win_read(input logic [31:0] idx, output logic [31:0] d);
        bus_write(12'h000, 4'd4, idx);
        bus_read(12'h010, d);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 mask all set", 32'(pin_mask), 32'hFFFFFF);
        check("R1 no update pulse", 32'(upd_valid), 0);
        bus_read(12'h000, d);   check("R1 select reset", d, 0);
        win_read(32'h10, d);    check("R1 entry0 low", d, 32'h00010000);
        win_read(32'h3E, d);    check("R1 entry23 low", d, 32'h00010000);
        win_read(32'h3F, d);    check("R1 entry23 high", d, 0);
    endtask

    task automatic t_version();
        logic [31:0] d;
        win_read(32'h1, d);     check("R5 version", d, 32'h00170011);
        bus_write(12'h010, 4'd4, 32'hFFFFFFFF);
        check("R5 no pulse on version write", 32'(upd_valid), 0);
        bus_read(12'h010, d);   check("R5 version write ignored", d, 32'h00170011);
    endtask

    task automatic t_id();
        logic [31:0] d;
        win_write(32'h0, 32'hA5FFFFFF);
        bus_read(12'h010, d);   check("R4 id index0", d, 32'h05000000);
        win_read(32'h2, d);     check("R4 id index2", d, 32'h05000000);
        bus_write(12'h010, 4'd4, 32'h0F000000);
        bus_read(12'h010, d);   check("R4 index2 write ignored", d, 32'h05000000);
    endtask

    task automatic t_entry();
        logic [31:0] d;
        win_write(32'h16, 32'h0000E931);   // entry 3 low
        check("R10 pulse after low write", 32'(upd_valid), 1);
        check("R10 pulse index", 32'(upd_index), 3);
        bus_read(12'h010, d);
        check("R7 low write clears remote", d, 32'h0000A931);
        check("R10 pulse lasts one cycle", 32'(upd_valid), 0);
        win_write(32'h17, 32'h7E000000);   // entry 3 high
        check("R10 pulse after high write", 32'(upd_valid), 1);
        check("R8 vector", 32'(pin_vector[3*8 +: 8]), 32'h31);
        check("R8 delivery mode", 32'(pin_dlv_mode[3*3 +: 3]), 1);
        check("R8 dest mode", 32'(pin_dst_mode[3]), 1);
        check("R8 polarity", 32'(pin_polarity[3]), 1);
        check("R8 level", 32'(pin_level[3]), 1);
        check("R8 mask", 32'(pin_mask[3]), 0);
        check("R8 dest", 32'(pin_dest[3*8 +: 8]), 32'h7E);
        check("R6 neighbour untouched", 32'(pin_mask[2] & pin_mask[4]), 1);
        bus_read(12'h010, d);   check("R6 entry3 high readback", d, 32'h7E000000);
        win_write(32'h3F, 32'hC3123456);   // entry 23 high
        check("R10 index of last entry", 32'(upd_index), 23);
        bus_read(12'h010, d);   check("R6 entry23 high", d, 32'hC3123456);
        check("R8 entry23 dest", 32'(pin_dest[23*8 +: 8]), 32'hC3);
    endtask

    task automatic t_remote();
        logic [31:0] d;
        @(negedge clk); remote_set[3] = 1'b1;
        @(negedge clk); remote_set[3] = 1'b0;
        check("R11 set strobe", 32'(pin_remote[3]), 1);
        win_read(32'h16, d);    check("R11 remote visible in window", d, 32'h0000E931);
        win_write(32'h17, 32'h7E000000);
        check("R7 high write keeps remote", 32'(pin_remote[3]), 1);
        @(negedge clk); remote_clr[3] = 1'b1;
        @(negedge clk); remote_clr[3] = 1'b0;
        check("R11 clear strobe", 32'(pin_remote[3]), 0);
        @(negedge clk); remote_set[3] = 1'b1; remote_clr[3] = 1'b1;
        @(negedge clk); remote_set[3] = 1'b0; remote_clr[3] = 1'b0;
        check("R11 clear beats set", 32'(pin_remote[3]), 0);
        bus_write(12'h000, 4'd4, 32'h16);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'h010; bus_wdata = 32'h0000E931; remote_set[3] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; remote_set[3] = 1'b0;
        check("R11 low write beats set", 32'(pin_remote[3]), 0);
        @(negedge clk); remote_set[3] = 1'b1;
        @(negedge clk); remote_set[3] = 1'b0;
        win_write(32'h16, 32'h0000E931);
        check("R7 low write clears held remote", 32'(pin_remote[3]), 0);
    endtask

    task automatic t_range();
        logic [31:0] d;
        win_read(32'h05, d);    check("R9 gap index reads zero", d, 0);
        bus_write(12'h010, 4'd4, 32'hFFFFFFFF);
        check("R9 gap write no pulse", 32'(upd_valid), 0);
        win_read(32'h40, d);    check("R9 past-end reads zero", d, 0);
        bus_write(12'h010, 4'd4, 32'hFFFFFFFF);
        check("R9 past-end write no pulse", 32'(upd_valid), 0);
        win_write(32'h41, 32'hFFFFFFFF);
        win_read(32'h3E, d);    check("R9 entry23 low unchanged", d, 32'h00010000);
        win_read(32'h3F, d);    check("R9 entry23 high unchanged", d, 32'hC3123456);
        win_read(32'h0, d);     check("R9 id unchanged", d, 32'h05000000);
    endtask

    task automatic t_offsets();
        logic [31:0] d;
        bus_write(12'h000, 4'd4, 32'h16);
        bus_read(12'h020, d);   check("R2 hole reads zero", d, 0);
        bus_write(12'h020, 4'd4, 32'h1);
        bus_read(12'h000, d);   check("R2 hole write ignored", d, 32'h16);
        bus_read(12'h110, d);   check("R2 address masked to 8 bits", d, 32'h0000A931);
        bus_write(12'h310, 4'd4, 32'h0001A955);
        check("R2 masked window write pulses", 32'(upd_valid), 1);
        check("R2 masked window write data", 32'(pin_vector[3*8 +: 8]), 32'h55);
    endtask

    task automatic t_size();
        logic [31:0] d;
        bus_write(12'h010, 4'd2, 32'h00000077);
        check("R3 size2 no pulse", 32'(upd_valid), 0);
        check("R3 size2 entry unchanged", 32'(pin_vector[3*8 +: 8]), 32'h55);
        bus_write(12'h000, 4'd1, 32'h20);
        bus_read(12'h000, d);   check("R3 size1 select ignored", d, 32'h16);
        bus_write(12'h010, 4'd8, 32'h00000088);
        check("R3 size8 accepted", 32'(pin_vector[3*8 +: 8]), 32'h88);
        check("R3 size8 clears mask", 32'(pin_mask[3]), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_version();
        t_id();
        t_entry();
        t_remote();
        t_range();
        t_offsets();
        t_size();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule